// File: doc/BRIEF.md
# Huge Page Leaf Splitter

This block sits in a hardware page-table walker at the point where a leaf has been found. It accepts one walk entry, an even/odd select and the walker's per-level index configuration. The result is an entry ready for a TLB that holds pages in even/odd pairs, together with the page-size exponent of that entry. The index configuration gives, for each level, the fault-address bit where the index starts and how many bits it has. Slot 0 describes the last page-table level. Slots 1 to 3 describe the directory levels.

When the entry has its huge flag set, the block turns it into one half of the huge page without touching memory. The level tag stored in the entry picks the configuration slot that sets the huge page size. The half-page exponent is that slot's base plus width minus one. The level tag and the huge flag are stripped, and a huge-global flag moves into the normal global position. The odd half sits one half-page above the even half.

When the huge flag is clear, the entry is a pointer to a page table. The block then reads the even or odd neighbour of the indexed PTE through a request/response port and returns the loaded value. A two-state machine drives the whole sequence. In IDLE, a start with a huge entry finishes in place (transition HUGE_DONE). A start with a table pointer moves to FETCH (transition ISSUE). FETCH holds the request until a response arrives and then returns to IDLE (transition RETURN).

Top module: `huge_leaf_splitter`

## Requirements
- R1: After reset, `done`, `mem_req`, `tlb_entry` and `page_exp` are all zero.
- R2: Bits of `leaf_entry` at or above PA_W (default 48) are cleared before any field is examined, so they never reach `tlb_entry` or `mem_addr`. Bits of `mem_rsp_data` at or above PA_W are also cleared before they reach `tlb_entry`.
- R3: For a huge entry (bit 6 set), the 2-bit level tag in bits 14:13 selects configuration slot 0..3. The selected slot's base and width set the page size.
- R4: In a huge result, bits 14:13 and the huge flag are cleared. All other bits below PA_W pass through unchanged, apart from R5 and R7.
- R5: If bit 12 of a huge entry is set, bit 12 is cleared in the result and bit 6 (global) is set.
- R6: For a huge entry, `page_exp` equals base + width - 1 of the selected slot.
- R7: With `odd_half` high, a huge result is the even result plus 2^`page_exp`. With `odd_half` low, the even result is returned unchanged.
- R8: A start in IDLE with a huge entry raises `done` in the next cycle and never raises `mem_req`.
- R9: A start in IDLE with a non-huge entry raises `mem_req` in the next cycle. The address is computed from the masked entry E, the slot-0 base B and width W, the fault address VA and the entry shift S. The index I is bits B..B+W-1 of VA, with bit 0 of I replaced by `odd_half`. The address is E OR (I << S).
- R10: A response accepted in FETCH raises `done` in the next cycle and drops `mem_req`. The result is the masked response data, and `page_exp` equals the slot-0 base.
- R11: While `mem_req` is high, `start` is ignored. The address stays stable, and no extra completion is produced.
- R12: `done` is a single-cycle strobe per completion. `tlb_entry` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin processing the presented entry |
| leaf_entry | input | EW | Entry found by the walk |
| odd_half | input | 1 | Select the odd half / odd neighbour |
| fault_va | input | VA_W | Faulting virtual address |
| lvl_base_cfg | input | NLVL*BW | Index start bit per slot (slot 0 = page table) |
| lvl_width_cfg | input | NLVL*WW | Index width per slot |
| ent_shift | input | SW | log2 of the PTE size in bytes |
| mem_req | output | 1 | Read request held until response |
| mem_addr | output | PA_W | Physical address of the PTE read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | EW | Read data |
| done | output | 1 | Result valid strobe |
| tlb_entry | output | EW | Resulting TLB half entry |
| page_exp | output | BW+1 | Page-size exponent of the result |

## Verification
The hardest case to reach from the ports is a start arriving while a fetch is outstanding. It needs a memory responder that deliberately withholds its answer for several cycles. The bench holds the response back and, in that window, pulses start with a huge entry that would otherwise complete at once. The scoreboard then flags any unexpected completion, and the address is rechecked. Huge entries are also driven with junk above the physical width and with every level tag, so that masking and slot selection are seen on the output.

// File: rtl/hps_pkg.sv
package hps_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } walk_state_e;

    // entry bit positions that the TLB and walker both decode
    localparam int HUGE_POS = 6;
    localparam int GLB_POS  = 6;
    localparam int HGLB_POS = 12;
    localparam int LVL_LO   = 13;
    localparam int LVL_W    = 2;
endpackage

// File: rtl/hps_level_sel.sv
module hps_level_sel #(
    parameter int NLVL = 4,
    parameter int BW   = 6,
    parameter int WW   = 6,
    parameter int LW   = 2
) (
    input  logic [NLVL*BW-1:0] base_cfg,
    input  logic [NLVL*WW-1:0] width_cfg,
    input  logic [LW-1:0]      lvl,
    output logic [BW-1:0]      sel_base,
    output logic [WW-1:0]      sel_width
);
    logic [BW-1:0] base_arr  [NLVL];
    logic [WW-1:0] width_arr [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_unpack
        assign base_arr[g]  = base_cfg[g*BW +: BW];
        assign width_arr[g] = width_cfg[g*WW +: WW];
    end

    always_comb begin
        sel_base  = base_arr[0];
        sel_width = width_arr[0];
        for (int i = 0; i < NLVL; i++) begin
            if (int'(lvl) == i) begin
                sel_base  = base_arr[i];
                sel_width = width_arr[i];
            end
        end
    end
endmodule

// File: rtl/hps_split.sv
module hps_split
    import hps_pkg::*;
#(
    parameter int EW    = 64,
    parameter int BW    = 6,
    parameter int WW    = 6,
    parameter int EXP_W = 7
) (
    input  logic [EW-1:0]    ent,
    input  logic             odd,
    input  logic [BW-1:0]    sz_base,
    input  logic [WW-1:0]    sz_width,
    output logic [EW-1:0]    half_ent,
    output logic [EXP_W-1:0] half_exp
);
    logic [EW-1:0] even_ent;

    always_comb begin
        even_ent = ent;
        even_ent[LVL_LO +: LVL_W] = '0;
        even_ent[HUGE_POS] = 1'b0;
        if (ent[HGLB_POS]) begin
            even_ent[HGLB_POS] = 1'b0;
            even_ent[GLB_POS]  = 1'b1;
        end
        // half of the huge page: one less than the full size exponent
        half_exp = EXP_W'(sz_base) + EXP_W'(sz_width) - EXP_W'(1);
        if (odd) begin
            half_ent = even_ent + (EW'(1) << half_exp);
        end else begin
            half_ent = even_ent;
        end
    end
endmodule

// File: rtl/hps_addr.sv
module hps_addr #(
    parameter int PA_W = 48,
    parameter int VA_W = 48,
    parameter int BW   = 6,
    parameter int WW   = 6,
    parameter int SW   = 3
) (
    input  logic [PA_W-1:0] tbl_base,
    input  logic [VA_W-1:0] va,
    input  logic            odd,
    input  logic [BW-1:0]   idx_lo,
    input  logic [WW-1:0]   idx_bits,
    input  logic [SW-1:0]   shift,
    output logic [PA_W-1:0] pte_addr
);
    logic [VA_W-1:0] va_sh;
    logic [VA_W-1:0] idx_mask;
    logic [VA_W-1:0] idx;

    always_comb begin
        va_sh = va >> idx_lo;
        for (int i = 0; i < VA_W; i++) begin
            idx_mask[i] = (i < int'(idx_bits));
        end
        idx    = va_sh & idx_mask;
        idx[0] = odd;
        pte_addr = tbl_base | (PA_W'(idx) << shift);
    end
endmodule

// File: rtl/huge_leaf_splitter.sv
module huge_leaf_splitter
    import hps_pkg::*;
#(
    parameter int EW   = 64,
    parameter int PA_W = 48,
    parameter int VA_W = 48,
    parameter int NLVL = 4,
    parameter int BW   = 6,
    parameter int WW   = 6,
    parameter int SW   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [EW-1:0]        leaf_entry,
    input  logic                 odd_half,
    input  logic [VA_W-1:0]      fault_va,
    input  logic [NLVL*BW-1:0]   lvl_base_cfg,
    input  logic [NLVL*WW-1:0]   lvl_width_cfg,
    input  logic [SW-1:0]        ent_shift,
    output logic                 mem_req,
    output logic [PA_W-1:0]      mem_addr,
    input  logic                 mem_rsp_valid,
    input  logic [EW-1:0]        mem_rsp_data,
    output logic                 done,
    output logic [EW-1:0]        tlb_entry,
    output logic [BW:0]          page_exp
);
    localparam int EXP_W = BW + 1;
    localparam logic [EW-1:0] PA_MASK = {{(EW-PA_W){1'b0}}, {PA_W{1'b1}}};

    walk_state_e state, state_nx;

    logic [EW-1:0]    ent_m;
    logic             is_huge;
    logic [BW-1:0]    hsel_base;
    logic [WW-1:0]    hsel_width;
    logic [EW-1:0]    split_ent;
    logic [EXP_W-1:0] split_exp;
    logic [PA_W-1:0]  fetch_addr;
    logic [BW-1:0]    pt_base;
    logic [WW-1:0]    pt_width;

    logic [PA_W-1:0]  addr_q;
    logic [EXP_W-1:0] pend_exp_q;
    logic             done_q;
    logic [EW-1:0]    ent_q;
    logic [EXP_W-1:0] exp_q;

    assign ent_m    = leaf_entry & PA_MASK;
    assign is_huge  = ent_m[HUGE_POS];
    assign pt_base  = lvl_base_cfg[BW-1:0];
    assign pt_width = lvl_width_cfg[WW-1:0];

    hps_level_sel #(.NLVL(NLVL), .BW(BW), .WW(WW), .LW(LVL_W)) u_lsel (
        .base_cfg  (lvl_base_cfg),
        .width_cfg (lvl_width_cfg),
        .lvl       (ent_m[LVL_LO +: LVL_W]),
        .sel_base  (hsel_base),
        .sel_width (hsel_width)
    );

    hps_split #(.EW(EW), .BW(BW), .WW(WW), .EXP_W(EXP_W)) u_split (
        .ent      (ent_m),
        .odd      (odd_half),
        .sz_base  (hsel_base),
        .sz_width (hsel_width),
        .half_ent (split_ent),
        .half_exp (split_exp)
    );

    hps_addr #(.PA_W(PA_W), .VA_W(VA_W), .BW(BW), .WW(WW), .SW(SW)) u_addr (
        .tbl_base (ent_m[PA_W-1:0]),
        .va       (fault_va),
        .odd      (odd_half),
        .idx_lo   (pt_base),
        .idx_bits (pt_width),
        .shift    (ent_shift),
        .pte_addr (fetch_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: ISSUE (IDLE->FETCH), RETURN (FETCH->IDLE)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start && !is_huge) state_nx = ST_FETCH;
            ST_FETCH: if (mem_rsp_valid)     state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            ent_q      <= '0;
            exp_q      <= '0;
            addr_q     <= '0;
            pend_exp_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && is_huge) begin
                        done_q <= 1'b1;
                        ent_q  <= split_ent;
                        exp_q  <= split_exp;
                    end else if (start) begin
                        addr_q     <= fetch_addr;
                        pend_exp_q <= EXP_W'(pt_base);
                    end
                end
                ST_FETCH: begin
                    if (mem_rsp_valid) begin
                        done_q <= 1'b1;
                        ent_q  <= mem_rsp_data & PA_MASK;
                        exp_q  <= pend_exp_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_req   = (state == ST_FETCH);
    assign mem_addr  = addr_q;
    assign done      = done_q;
    assign tlb_entry = ent_q;
    assign page_exp  = exp_q;
endmodule

module hls_chk #(
    parameter int EW   = 64,
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            huge_in,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic [EW-1:0]   tlb_entry
);
    // R8
    huge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mem_req && huge_in |=> done && !mem_req);

    // R9
    fetch_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mem_req && !huge_in |=> mem_req && !done);

    // R10
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rsp_valid |=> done && !mem_req);

    // R11
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && !done);

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(tlb_entry));
endmodule

bind huge_leaf_splitter hls_chk #(.EW(EW), .PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .huge_in       (leaf_entry[6]),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .tlb_entry     (tlb_entry)
);

// File: tb/tb_huge_leaf_splitter.sv
module tb_huge_leaf_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 64, PA_W = 48, VA_W = 48, NLVL = 4, BW = 6, WW = 6, SW = 3;
    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

    typedef struct {
        logic [63:0] ent;
        logic [6:0]  ex;
        string       req;
    } exp_t;

    logic clk = 0, rst_n = 0, start = 0, odd_half = 0;
    logic [EW-1:0] leaf_entry = '0;
    logic [VA_W-1:0] fault_va = '0;
    logic [NLVL*BW-1:0] lvl_base_cfg;
    logic [NLVL*WW-1:0] lvl_width_cfg;
    logic [SW-1:0] ent_shift = 3'd3;
    logic mem_req, mem_rsp_valid = 0, done;
    logic [PA_W-1:0] mem_addr;
    logic [EW-1:0] mem_rsp_data = '0, tlb_entry;
    logic [BW:0] page_exp;

    int cfg_b [NLVL] = '{12, 21, 30, 39};
    int cfg_w [NLVL] = '{9, 9, 9, 8};

    int n_cmp = 0, n_bad = 0, cyc = 0;
    exp_t sb[$];
    logic [PA_W-1:0] exp_addr;
    logic [63:0] rsp_next;
    int rsp_delay = 0, wait_cnt = 0;
    bit rsp_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    huge_leaf_splitter #(.EW(EW), .PA_W(PA_W), .VA_W(VA_W), .NLVL(NLVL),
                         .BW(BW), .WW(WW), .SW(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .leaf_entry(leaf_entry),
        .odd_half(odd_half), .fault_va(fault_va), .lvl_base_cfg(lvl_base_cfg),
        .lvl_width_cfg(lvl_width_cfg), .ent_shift(ent_shift), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .tlb_entry(tlb_entry), .page_exp(page_exp)
    );

    always_comb begin
        for (int i = 0; i < NLVL; i++) begin
            lvl_base_cfg[i*BW +: BW]  = BW'(cfg_b[i]);
            lvl_width_cfg[i*WW +: WW] = WW'(cfg_w[i]);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // expected huge result built from R2..R7
    function automatic logic [63:0] ref_huge(input logic [63:0] e, input bit odd,
                                             output logic [6:0] ps);
        logic [63:0] m, o;
        int lvl;
        m   = e & PA_MASK;
        lvl = int'(m[14:13]);
        ps  = 7'(cfg_b[lvl] + cfg_w[lvl] - 1);
        o   = m;
        o[14:13] = 2'b00;
        o[6] = 1'b0;
        if (m[12]) begin
            o[12] = 1'b0;
            o[6]  = 1'b1;
        end
        if (odd) o = o + (64'd1 << ps);
        return o;
    endfunction

    // monitor: pops expected items at every completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected completion", tlb_entry, 64'd0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(tlb_entry == x.ent, x.req, "tlb_entry", tlb_entry, x.ent);
                check(page_exp == x.ex, x.req, "page_exp", 64'(page_exp), 64'(x.ex));
            end
        end
    end

    // memory responder with programmable delay
    always @(negedge clk) begin
        if (rsp_flag) begin
            check(done == 1'b1, "R10", "done after response", 64'(done), 64'd1);
            rsp_flag = 0;
        end
        if (mem_req && !mem_rsp_valid) begin
            if (wait_cnt == rsp_delay) begin
                check(mem_addr == exp_addr, "R9", "mem_addr", 64'(mem_addr), 64'(exp_addr));
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rsp_next;
                rsp_flag = 1;
            end else begin
                wait_cnt++;
            end
        end else begin
            mem_rsp_valid = 1'b0;
            wait_cnt = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run_huge(input logic [63:0] e, input bit odd, input string req);
        exp_t x;
        x.ent = ref_huge(e, odd, x.ex);
        x.req = req;
        sb.push_back(x);
        @(negedge clk);
        leaf_entry = e; odd_half = odd; start = 1;
        @(negedge clk);
        start = 0;
        check(done == 1'b1 && mem_req == 1'b0, "R8", "huge one-cycle done",
              64'({done, mem_req}), 64'b10);
        @(negedge clk);
        check(done == 1'b0, "R12", "done single pulse", 64'(done), 64'd0);
    endtask

    task automatic run_normal(input logic [63:0] e, input bit odd, input logic [47:0] va,
                              input int dly, input logic [63:0] data, input bit poke,
                              input string req);
        exp_t x;
        logic [63:0] idx;
        idx = (64'(va) >> cfg_b[0]) & ((64'd1 << cfg_w[0]) - 64'd1);
        idx[0] = odd;
        exp_addr  = PA_W'((e & PA_MASK) | (idx << 3));
        rsp_next  = data;
        rsp_delay = dly;
        x.ent = data & PA_MASK;
        x.ex  = 7'(cfg_b[0]);
        x.req = req;
        sb.push_back(x);
        @(negedge clk);
        leaf_entry = e; odd_half = odd; fault_va = va; start = 1;
        @(negedge clk);
        start = 0;
        check(mem_req == 1'b1, "R9", "request raised", 64'(mem_req), 64'd1);
        if (poke) begin
            // R11: huge entry presented while the fetch is outstanding
            leaf_entry = 64'h0000_0000_4000_2041; start = 1;
            @(negedge clk);
            start = 0;
            check(mem_addr == exp_addr && mem_req, "R11", "addr held while busy",
                  64'(mem_addr), 64'(exp_addr));
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(mem_req == 1'b0, "R10", "request dropped", 64'(mem_req), 64'd0);
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check(done == 0 && mem_req == 0 && tlb_entry == 0 && page_exp == 0, "R1",
              "reset state", 64'({done, mem_req, |tlb_entry, |page_exp}), 64'd0);
        rst_n = 1;
        // level 1 (R3, R4, R6), even then odd (R7)
        run_huge(64'h0000_0080_0000_2043, 1'b0, "R3/R4/R6");
        run_huge(64'h0000_0080_0000_2043, 1'b1, "R7");
        // level 2 with huge-global (R5)
        run_huge(64'h0000_0100_0000_5053, 1'b1, "R5");
        // level 0 with junk above physical width (R2)
        run_huge(64'hABCD_0000_0120_0047, 1'b0, "R2");
        // level 3 with huge-global, odd
        run_huge(64'h0000_8000_0000_7041, 1'b1, "R3");
        // table pointer fetches (R9, R10)
        run_normal(64'h0000_0000_0040_0000, 1'b0, 48'h0000_1234_5000, 0,
                   64'h0000_0000_0ABC_D01F, 1'b0, "R10");
        run_normal(64'hFF00_0000_0080_0000, 1'b1, 48'h0000_1234_5000, 2,
                   64'hDEAD_0012_3456_7003, 1'b0, "R2");
        // start during fetch ignored (R11)
        run_normal(64'h0000_0000_00C0_0000, 1'b0, 48'h0000_0FFF_F000, 4,
                   64'h0000_0000_7777_7001, 1'b1, "R11");
        // result held between completions (R12)
        held = tlb_entry;
        repeat (4) @(negedge clk);
        check(tlb_entry == held, "R12", "entry held", tlb_entry, held);
        check(sb.size() == 0, "R11", "all completions seen", 64'(sb.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule